// File: doc/BRIEF.md
# Rotating Disk Sector and Index Timing Model

This block is a timing model of a spinning cartridge disk. A clock-cycle divider sets the sector period, which stands for 5 ms of disk time. On each period boundary the block gives a one-cycle sector pulse. Once per revolution that pulse is joined, in the same cycle, by a one-cycle index pulse. The block also reports the number of the sector now passing the head. The index mark is the sector where the count returns to zero.

After reset, the model must pass a startup sequence before the memory access engine may ask for data. In the normal start, the first event is a plain sector pulse and the second carries the index. Two more sector pulses must then pass before the data-request enable rises. A fast-start select, sampled while reset is held, places the model so that its very first pulse is the index. This removes one sector period from the wait, which helps long simulations.

Top module: `spin_mark_gen`

## Requirements
- R1: `sector_mark` is a one-cycle pulse. It first appears on the TICKS_PER_SECTOR-th rising edge after reset is released, and then every TICKS_PER_SECTOR cycles after that.
- R2: `index_mark` is a one-cycle pulse and is high only in a cycle where `sector_mark` is also high.
- R3: With `fast_start` low during reset, the first sector pulse carries no index and the second sector pulse carries the index.
- R4: With `fast_start` high during reset, the first sector pulse carries the index.
- R5: `sector_num` changes only in cycles with a sector pulse. On each pulse it steps by one modulo SECTORS_PER_REV, and `index_mark` is high exactly when it steps to 0. Its value during reset is SECTORS_PER_REV-2 with `fast_start` low, and SECTORS_PER_REV-1 with `fast_start` high.
- R6: `req_enable` is low until the SETTLE_MARKS-th sector pulse after the first index pulse (by default the second), and it rises in the same cycle as that pulse.
- R7: Once high, `req_enable` stays high until reset. While reset is held, `sector_mark`, `index_mark` and `req_enable` are 0.
- R8: `fast_start` is sampled only while reset is held. Changing it afterwards has no effect on the pulses, the sector number or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_start | input | 1 | Startup select, sampled during reset: 1 starts at the index |
| sector_mark | output | 1 | One-cycle sector pulse |
| index_mark | output | 1 | One-cycle index pulse, coincident with a sector pulse |
| sector_num | output | SEC_W | Number of the sector now under the head |
| req_enable | output | 1 | Data requests allowed; sticky until reset |

## Verification
The following properties are checked on every cycle:
- the exact spacing between sector pulses, measured by a gap counter;
- that an index pulse only ever sits on a sector pulse and lands on sector 0;
- that the sector number holds still between pulses;
- that the enable rises only together with a sector pulse and never falls outside reset.

Some behaviour can only be shown by the bench's scenarios:
- which pulse carries the first index in each startup mode;
- which pulse raises the enable;
- the reset values of the sector number;
- that `fast_start` is ignored once the model runs.

// File: rtl/spin_pkg.sv
package spin_pkg;

   typedef enum logic [1:0] {
      PH_SEEK   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_READY  = 2'd2
   } spin_phase_e;

   // Bits needed to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/spin_tick_div.sv
module spin_tick_div #(
   parameter int unsigned TICKS = 1250000
) (
   input  logic clk,
   input  logic rst,
   output logic wrap
);
   localparam int unsigned TW = spin_pkg::cnt_w(TICKS);
   localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

   logic [TW-1:0] cnt_q;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/spin_sector_ctr.sv
module spin_sector_ctr #(
   parameter int unsigned SECTORS = 16,
   parameter int unsigned SW      = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fast_start,
   input  logic          wrap,
   output logic          sm_q,
   output logic          im_q,
   output logic [SW-1:0] sector_q,
   output logic          index_hit
);
   localparam logic [SW-1:0] LAST = SW'(SECTORS - 1);
   localparam logic [SW-1:0] PRE  = SW'(SECTORS - 2);

   logic          at_last;
   logic [SW-1:0] sector_nx;

   assign at_last   = (sector_q == LAST);
   assign index_hit = wrap && at_last;

   generate
      if ((1 << SW) == SECTORS) begin : g_pow2
         // Counter overflows naturally at the revolution length.
         assign sector_nx = sector_q + 1'b1;
      end else begin : g_cmp
         assign sector_nx = at_last ? '0 : sector_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sm_q     <= 1'b0;
         im_q     <= 1'b0;
         sector_q <= fast_start ? LAST : PRE;
      end else begin
         sm_q <= wrap;
         im_q <= index_hit;
         if (wrap) sector_q <= sector_nx;
      end
   end

   // R2
   index_on_sector_chk: assert property (@(posedge clk) disable iff (rst)
      im_q |-> sm_q);

   // R5
   index_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
      im_q |-> (sector_q == '0));

endmodule

// File: rtl/spin_startup_seq.sv
module spin_startup_seq #(
   parameter int unsigned SETTLE = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic wrap,
   input  logic index_hit,
   output logic en_q
);
   import spin_pkg::*;

   localparam int unsigned CW = cnt_w(SETTLE + 1);
   localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

   spin_phase_e   phase_q, phase_d;
   logic [CW-1:0] settle_q, settle_d;

   always_comb begin
      phase_d  = phase_q;
      settle_d = settle_q;
      if (wrap) begin
         unique case (phase_q)
            PH_SEEK: begin
               if (index_hit) begin
                  phase_d  = PH_SETTLE;
                  settle_d = '0;
               end
            end
            PH_SETTLE: begin
               settle_d = settle_q + 1'b1;
               if (settle_q == LAST) phase_d = PH_READY;
            end
            PH_READY: phase_d = PH_READY;
            default:  phase_d = PH_SEEK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= PH_SEEK;
         settle_q <= '0;
         en_q     <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         settle_q <= settle_d;
         en_q     <= (phase_d == PH_READY);
      end
   end

   // R7
   enable_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      en_q |=> en_q);

endmodule

// File: rtl/spin_mark_gen.sv
module spin_mark_gen #(
   parameter int unsigned TICKS_PER_SECTOR = 1250000,
   parameter int unsigned SECTORS_PER_REV  = 16,
   parameter int unsigned SETTLE_MARKS     = 2,
   localparam int unsigned SEC_W = spin_pkg::cnt_w(SECTORS_PER_REV)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fast_start,
   output logic             sector_mark,
   output logic             index_mark,
   output logic [SEC_W-1:0] sector_num,
   output logic             req_enable
);
   localparam int unsigned GW = spin_pkg::cnt_w(TICKS_PER_SECTOR + 1);

   generate
      if (TICKS_PER_SECTOR < 2) begin : g_bad_ticks
         $error("TICKS_PER_SECTOR must be at least 2");
      end
      if (SECTORS_PER_REV < 2) begin : g_bad_sectors
         $error("SECTORS_PER_REV must be at least 2");
      end
      if (SETTLE_MARKS < 1) begin : g_bad_settle
         $error("SETTLE_MARKS must be at least 1");
      end
   endgenerate

   logic wrap;
   logic index_hit;

   spin_tick_div #(.TICKS(TICKS_PER_SECTOR)) u_div (
      .clk  (clk),
      .rst  (rst),
      .wrap (wrap)
   );

   spin_sector_ctr #(.SECTORS(SECTORS_PER_REV), .SW(SEC_W)) u_sec (
      .clk        (clk),
      .rst        (rst),
      .fast_start (fast_start),
      .wrap       (wrap),
      .sm_q       (sector_mark),
      .im_q       (index_mark),
      .sector_q   (sector_num),
      .index_hit  (index_hit)
   );

   spin_startup_seq #(.SETTLE(SETTLE_MARKS)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .wrap      (wrap),
      .index_hit (index_hit),
      .en_q      (req_enable)
   );

   // Port-level gap counter used only by the checks below.
   logic [GW-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (rst)              gap_q <= '0;
      else if (sector_mark) gap_q <= GW'(1);
      else                  gap_q <= gap_q + 1'b1;
   end

   // R1
   mark_period_chk: assert property (@(posedge clk) disable iff (rst)
      sector_mark |-> (gap_q == GW'(TICKS_PER_SECTOR)));

   // R1
   mark_overdue_chk: assert property (@(posedge clk) disable iff (rst)
      !sector_mark |-> (gap_q < GW'(TICKS_PER_SECTOR)));

   // R5
   sector_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !sector_mark |-> (sector_num == $past(sector_num)));

   // R6
   enable_on_mark_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(req_enable) |-> sector_mark);

endmodule

// File: tb/spin_mark_gen_bench.sv
`timescale 1ns/1ps
module spin_mark_gen_bench;
   localparam int T  = 8;
   localparam int N  = 4;
   localparam int SW = spin_pkg::cnt_w(N);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fast_start = 1'b0;
   logic sector_mark, index_mark, req_enable;
   logic [SW-1:0] sector_num;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spin_mark_gen #(.TICKS_PER_SECTOR(T), .SECTORS_PER_REV(N), .SETTLE_MARKS(2))
   u_spin_mark_gen (
      .clk(clk), .rst(rst), .fast_start(fast_start),
      .sector_mark(sector_mark), .index_mark(index_mark),
      .sector_num(sector_num), .req_enable(req_enable)
   );

   // Expected per-pulse values: normal start (R3, R5, R6) and fast start (R4).
   localparam int NRM_SEC[8] = '{3, 0, 1, 2, 3, 0, 1, 2};
   localparam int NRM_IM [8] = '{0, 1, 0, 0, 0, 1, 0, 0};
   localparam int NRM_EN [8] = '{0, 0, 0, 1, 1, 1, 1, 1};
   localparam int FST_SEC[5] = '{0, 1, 2, 3, 0};
   localparam int FST_IM [5] = '{1, 0, 0, 0, 1};
   localparam int FST_EN [5] = '{0, 0, 1, 1, 1};

   task automatic chk(input string rq, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // One sector period: T-1 quiet cycles, then the pulse cycle.
   task automatic interval(input string tag, input int e_sec, input int e_im, input int e_en);
      int marks = 0, idx = 0, moves = 0, en_moves = 0;
      int sec0 = sector_num;
      int en0  = req_enable;
      for (int c = 1; c < T; c++) begin
         @(posedge clk); #1;
         marks    += sector_mark;
         idx      += index_mark;
         moves    += (sector_num != sec0);
         en_moves += (req_enable != en0);
      end
      chk({tag, " R1 quiet pulses"}, marks, 0);
      chk({tag, " R2 quiet index"}, idx, 0);
      chk({tag, " R5 sector held"}, moves, 0);
      chk({tag, " R7 enable held"}, en_moves, 0);
      @(posedge clk); #1;
      chk({tag, " R1 pulse"}, sector_mark, 1);
      chk({tag, " R2 R3 R4 index"}, index_mark, e_im);
      chk({tag, " R5 sector"}, sector_num, e_sec);
      chk({tag, " R6 enable"}, req_enable, e_en);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      // Reset state, normal start (R7, R5)
      fast_start = 1'b0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R7 reset sector_mark", sector_mark, 0);
      chk("R7 reset index_mark", index_mark, 0);
      chk("R7 reset req_enable", req_enable, 0);
      chk("R5 reset sector normal", sector_num, N-2);
      @(negedge clk) rst = 1'b0;

      // Normal-start table walk; fast_start toggled mid-run (R8)
      for (int v = 0; v < 8; v++) begin
         if (v == 2) fast_start = 1'b1;
         if (v == 5) fast_start = 1'b0;
         if (v == 6) fast_start = 1'b1;
         interval($sformatf("normal e%0d R8", v+1), NRM_SEC[v], NRM_IM[v], NRM_EN[v]);
      end
      @(posedge clk); #1;
      chk("R1 pulse width", sector_mark, 0);
      chk("R2 index width", index_mark, 0);

      // Mid-run reset clears the enable; fast start sampled (R7, R5)
      fast_start = 1'b1;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R7 mid-run reset req_enable", req_enable, 0);
      chk("R7 mid-run reset sector_mark", sector_mark, 0);
      chk("R5 reset sector fast", sector_num, N-1);
      @(negedge clk) rst = 1'b0;

      for (int v = 0; v < 5; v++)
         interval($sformatf("fast e%0d R4", v+1), FST_SEC[v], FST_IM[v], FST_EN[v]);

      finish_run();
   end

endmodule